// File: doc/BRIEF.md
# Virtual Address Translation Buffer

This unit turns 32-bit virtual addresses into physical ones through a small, fully associative cache of page translations. Every entry's page tag is compared with the incoming page at the same time. When several entries match, a priority picker chooses one, and that index selects the frame number and permission bits held in a companion store. A lookup is registered: the physical address and its status flags appear one clock after the map request and stay there until the next map request.

The same unit also carries out the maintenance operations that software uses on the buffer. It can search for a page, read an entry, write an entry at a given slot, or write an entry at a pseudo-random slot. The surrounding controller owns the index, entry-high and entry-low registers. It passes their current values into the unit and takes back a one-cycle write enable and a new value for each of them. Addresses whose two top bits are both set bypass the buffer entirely. The replacement slot comes from a down-counter that moves only when a translation is requested. That counter never lands in the lowest few slots, so those slots can hold fixed mappings.

Top module: `xlate_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `paddr`, all four status flags and all three write enables are 0. Reset also empties every entry: tag 0, frame 0, both permission bits 0. Reset sets the replacement slot to ENTRIES-1.
- R2: Function codes are hold=0, map=1, search=2, random write=3, indexed read=4, indexed write=5. A map of a non-bypass address whose page matches an entry drives `paddr` = {entry frame, vaddr[11:0]} after the next rising edge. In that case both miss flags are 0.
- R3: On a map hit, `invalid` equals the inverse of the entry's valid bit and `wprot` equals the inverse of its write bit. Entry-low bit 0 is the valid bit, bit 1 is the write bit, and bits 31:12 are the frame.
- R4: On a map miss, `paddr` is 0 and `invalid` and `wprot` are 0. `miss_k` is set when vaddr[31] is 1 and `miss_u` when it is 0; they are never both set.
- R5: A map with vaddr[31:30] = 2'b11 gives `paddr` = vaddr with bits 31:30 cleared, and all four flags 0, whatever the buffer holds.
- R6: Under the hold code, `paddr` and the four flags keep their values.
- R7: A search compares entry-high bits 31:12 with every tag. One cycle later `idx_we` pulses, and `idx_new` is the matching slot, zero-extended, or 32'h8000_0000 if nothing matched.
- R8: An indexed read of slot idx_reg[4:0] pulses `ehi_we` and `elo_we` one cycle later. `ehi_new` = {tag, 12'b0} and `elo_new` = {frame, 10'b0, write, valid}.
- R9: An indexed write stores entry-high bits 31:12 as the tag, and entry-low frame, write and valid bits, into slot idx_reg[4:0].
- R10: A random write stores the entry into the current replacement slot. That slot decrements by one on every map request and on nothing else. A decrement from RSVD wraps to ENTRIES-1.
- R11: When several entries match a page, the one with the lowest slot number is used for both map and search.
- R12: Write enables are single-cycle pulses. Only a search raises `idx_we`, and only an indexed read raises `ehi_we` and `elo_we`. Map, hold and both write operations raise none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| func | input | 3 | Operation code |
| vaddr | input | 32 | Virtual address for map |
| idx_reg | input | 32 | Current index register value |
| ehi_reg | input | 32 | Current entry-high register value |
| elo_reg | input | 32 | Current entry-low register value |
| paddr | output | 32 | Translated physical address |
| miss_k | output | 1 | Miss on a kernel-half address |
| miss_u | output | 1 | Miss on a user-half address |
| invalid | output | 1 | Hit on an entry with valid bit clear |
| wprot | output | 1 | Hit on an entry with write bit clear |
| idx_we | output | 1 | Index register write pulse |
| idx_new | output | 32 | New index register value |
| ehi_we | output | 1 | Entry-high register write pulse |
| ehi_new | output | 32 | New entry-high value |
| elo_we | output | 1 | Entry-low register write pulse |
| elo_new | output | 32 | New entry-low value |

## Verification
The bench builds the unit with its defaults: 32 entries, 4 reserved low slots and 4 KiB pages. With these values the replacement slot walks from 31 down to 4 within a few dozen map requests. That puts both the wrap back to 31 and the lowest usable slot within reach of short directed sequences. Because there are 32 slots, two entries holding the same page can sit far apart, which exercises the lowest-slot preference. It also leaves room for the unmatched-search marker in bit 31 of the index value.

// File: rtl/xlate_pkg.sv
// Shared definitions for the translation buffer unit.
// Assumes a 3-bit operation code supplied by the controlling state machine.
package xlate_pkg;
    typedef enum logic [2:0] {
        XF_HOLD = 3'd0,
        XF_MAP  = 3'd1,
        XF_SRCH = 3'd2,
        XF_WRND = 3'd3,
        XF_RDIX = 3'd4,
        XF_WRIX = 3'd5
    } xfunc_e;
endpackage

// File: rtl/xlate_cam.sv
// Tag store with parallel comparators and a lowest-slot priority picker.
// Assumes one write port and one combinational lookup port; reset clears tags.
module xlate_cam #(
    parameter int ENTRIES = 32,
    parameter int PN_W    = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [PN_W-1:0]  wr_page,
    input  logic [PN_W-1:0]  lk_page,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx,
    output logic [PN_W-1:0]  rd_page
);
    logic [PN_W-1:0]    tags [ENTRIES];
    logic [ENTRIES-1:0] match;

    // Tag storage: cleared on reset, one slot written per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) tags[i] <= '0;
        end else if (wr_en) begin
            tags[wr_idx] <= wr_page;
        end
    end

    // One equality comparator per slot.
    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
            assign match[g] = (tags[g] == lk_page);
        end
    endgenerate

    // Priority picker: the lowest matching slot wins.
    always_comb begin
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) hit_idx = IDX_W'(i);
        end
    end

    assign hit     = |match;
    assign rd_page = tags[rd_idx];
endmodule

// File: rtl/xlate_frames.sv
// Frame number and permission store, read through two combinational ports.
// Assumes port A follows the lookup result and port B the index register.
module xlate_frames #(
    parameter int ENTRIES = 32,
    parameter int FN_W    = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [FN_W-1:0]  wr_frame,
    input  logic             wr_w,
    input  logic             wr_v,
    input  logic [IDX_W-1:0] a_idx,
    output logic [FN_W-1:0]  a_frame,
    output logic             a_w,
    output logic             a_v,
    input  logic [IDX_W-1:0] b_idx,
    output logic [FN_W-1:0]  b_frame,
    output logic             b_w,
    output logic             b_v
);
    logic [FN_W-1:0]    frames [ENTRIES];
    logic [ENTRIES-1:0] wbits;
    logic [ENTRIES-1:0] vbits;

    // Entry payload storage, cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) frames[i] <= '0;
            wbits <= '0;
            vbits <= '0;
        end else if (wr_en) begin
            frames[wr_idx] <= wr_frame;
            wbits[wr_idx]  <= wr_w;
            vbits[wr_idx]  <= wr_v;
        end
    end

    assign a_frame = frames[a_idx];
    assign a_w     = wbits[a_idx];
    assign a_v     = vbits[a_idx];
    assign b_frame = frames[b_idx];
    assign b_w     = wbits[b_idx];
    assign b_v     = vbits[b_idx];
endmodule

// File: rtl/xlate_rand.sv
// Replacement slot counter: steps down once per map request.
// Assumes RSVD < ENTRIES; wraps from RSVD back to ENTRIES-1.
module xlate_rand #(
    parameter int ENTRIES = 32,
    parameter int RSVD    = 4,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [IDX_W-1:0] slot
);
    localparam logic [IDX_W-1:0] TOP = IDX_W'(ENTRIES - 1);
    localparam logic [IDX_W-1:0] BOT = IDX_W'(RSVD);

    // Down-count with wrap that skips the reserved low slots.
    always_ff @(posedge clk) begin
        if (!rst_n)          slot <= TOP;
        else if (step)       slot <= (slot == BOT) ? TOP : slot - 1'b1;
    end
endmodule

// File: rtl/xlate_unit.sv
// Translation buffer unit: registered map lookup, maintenance operations,
// bypass of the top address quarter, and kernel/user miss split.
// Assumes the controller applies the returned register values on the *_we pulses.
module xlate_unit #(
    parameter int ENTRIES   = 32,
    parameter int RSVD      = 4,
    parameter int VA_W      = 32,
    parameter int PAGE_BITS = 12,
    localparam int IDX_W    = $clog2(ENTRIES),
    localparam int PN_W     = VA_W - PAGE_BITS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      func,
    input  logic [VA_W-1:0] vaddr,
    input  logic [VA_W-1:0] idx_reg,
    input  logic [VA_W-1:0] ehi_reg,
    input  logic [VA_W-1:0] elo_reg,
    output logic [VA_W-1:0] paddr,
    output logic            miss_k,
    output logic            miss_u,
    output logic            invalid,
    output logic            wprot,
    output logic            idx_we,
    output logic [VA_W-1:0] idx_new,
    output logic            ehi_we,
    output logic [VA_W-1:0] ehi_new,
    output logic            elo_we,
    output logic [VA_W-1:0] elo_new
);
    import xlate_pkg::*;

    xfunc_e           fn;
    logic             direct;
    logic             wr_any;
    logic [IDX_W-1:0] rnd_idx;
    logic [IDX_W-1:0] wr_slot;
    logic [IDX_W-1:0] ix_slot;
    logic [PN_W-1:0]  lk_page;
    logic             hit;
    logic [IDX_W-1:0] hit_idx;
    logic [PN_W-1:0]  rd_page;
    logic [PN_W-1:0]  hit_frame;
    logic             hit_w;
    logic             hit_v;
    logic [PN_W-1:0]  rd_frame;
    logic             rd_w;
    logic             rd_v;
    logic             unused_bits;

    assign fn      = xfunc_e'(func);
    assign direct  = &vaddr[VA_W-1:VA_W-2];
    assign wr_any  = (fn == XF_WRIX) || (fn == XF_WRND);
    assign ix_slot = idx_reg[IDX_W-1:0];
    assign wr_slot = (fn == XF_WRND) ? rnd_idx : ix_slot;
    assign lk_page = (fn == XF_SRCH) ? ehi_reg[VA_W-1:PAGE_BITS]
                                     : vaddr[VA_W-1:PAGE_BITS];
    assign unused_bits = ^{idx_reg[VA_W-1:IDX_W], ehi_reg[PAGE_BITS-1:0],
                           elo_reg[PAGE_BITS-1:2]};

    xlate_cam #(.ENTRIES(ENTRIES), .PN_W(PN_W)) u_cam (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_any),
        .wr_idx  (wr_slot),
        .wr_page (ehi_reg[VA_W-1:PAGE_BITS]),
        .lk_page (lk_page),
        .rd_idx  (ix_slot),
        .hit     (hit),
        .hit_idx (hit_idx),
        .rd_page (rd_page)
    );

    xlate_frames #(.ENTRIES(ENTRIES), .FN_W(PN_W)) u_frm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_any),
        .wr_idx   (wr_slot),
        .wr_frame (elo_reg[VA_W-1:PAGE_BITS]),
        .wr_w     (elo_reg[1]),
        .wr_v     (elo_reg[0]),
        .a_idx    (hit_idx),
        .a_frame  (hit_frame),
        .a_w      (hit_w),
        .a_v      (hit_v),
        .b_idx    (ix_slot),
        .b_frame  (rd_frame),
        .b_w      (rd_w),
        .b_v      (rd_v)
    );

    xlate_rand #(.ENTRIES(ENTRIES), .RSVD(RSVD)) u_rnd (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (fn == XF_MAP),
        .slot  (rnd_idx)
    );

    // Translation result register: updated only by map requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paddr   <= '0;
            miss_k  <= 1'b0;
            miss_u  <= 1'b0;
            invalid <= 1'b0;
            wprot   <= 1'b0;
        end else if (fn == XF_MAP) begin
            if (direct) begin
                paddr   <= {2'b00, vaddr[VA_W-3:0]};
                miss_k  <= 1'b0;
                miss_u  <= 1'b0;
                invalid <= 1'b0;
                wprot   <= 1'b0;
            end else if (!hit) begin
                paddr   <= '0;
                miss_k  <= vaddr[VA_W-1];
                miss_u  <= !vaddr[VA_W-1];
                invalid <= 1'b0;
                wprot   <= 1'b0;
            end else begin
                paddr   <= {hit_frame, vaddr[PAGE_BITS-1:0]};
                miss_k  <= 1'b0;
                miss_u  <= 1'b0;
                invalid <= !hit_v;
                wprot   <= !hit_w;
            end
        end
    end

    // Register write-back pulses and values for search and indexed read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_we  <= 1'b0;
            idx_new <= '0;
            ehi_we  <= 1'b0;
            ehi_new <= '0;
            elo_we  <= 1'b0;
            elo_new <= '0;
        end else begin
            idx_we <= 1'b0;
            ehi_we <= 1'b0;
            elo_we <= 1'b0;
            if (fn == XF_SRCH) begin
                idx_we  <= 1'b1;
                idx_new <= hit ? VA_W'(hit_idx) : {1'b1, {(VA_W-1){1'b0}}};
            end
            if (fn == XF_RDIX) begin
                ehi_we  <= 1'b1;
                ehi_new <= {rd_page, {PAGE_BITS{1'b0}}};
                elo_we  <= 1'b1;
                elo_new <= {rd_frame, {(PAGE_BITS-2){1'b0}}, rd_w, rd_v};
            end
        end
    end
endmodule

// File: rtl/xlate_unit_chk.sv
// Property checker for xlate_unit, attached by bind below.
// Assumes it observes the top ports plus the replacement slot.
module xlate_unit_chk #(
    parameter int ENTRIES = 32,
    parameter int RSVD    = 4,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       func,
    input logic [31:0]      vaddr,
    input logic [31:0]      paddr,
    input logic             miss_k,
    input logic             miss_u,
    input logic             invalid,
    input logic             wprot,
    input logic             idx_we,
    input logic             ehi_we,
    input logic             elo_we,
    input logic [IDX_W-1:0] rnd
);
    // R4: the two miss flags never coexist.
    p_miss_split_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(miss_k && miss_u));

    // R4: a miss suppresses the permission flags.
    p_miss_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_k || miss_u) |-> (!invalid && !wprot));

    // R5: bypass addresses clear the top bits and all flags.
    p_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (func == 3'd1 && vaddr[31:30] == 2'b11) |=>
        (paddr == {2'b00, $past(vaddr[29:0])} && !miss_k && !miss_u && !invalid && !wprot));

    // R6: hold keeps the translation result.
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (func == 3'd0) |=> ($stable(paddr) && $stable(miss_k) && $stable(miss_u)
                            && $stable(invalid) && $stable(wprot)));

    // R10: the slot stays out of the reserved range.
    p_slot_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rnd >= IDX_W'(RSVD));

    // R10: a map steps the slot down by one away from the wrap point.
    p_slot_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (func == 3'd1 && rnd != IDX_W'(RSVD)) |=>
        (rnd == $past(rnd) - {{(IDX_W-1){1'b0}}, 1'b1}));

    // R10: the wrap returns to the top slot.
    p_slot_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (func == 3'd1 && rnd == IDX_W'(RSVD)) |=> (rnd == IDX_W'(ENTRIES - 1)));

    // R10: anything other than a map leaves the slot alone.
    p_slot_still_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (func != 3'd1) |=> $stable(rnd));

    // R12: pulses follow only their own operations.
    p_idx_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (func != 3'd2) |=> !idx_we);

    p_entry_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (func != 3'd4) |=> (!ehi_we && !elo_we));
endmodule

bind xlate_unit xlate_unit_chk #(.ENTRIES(ENTRIES), .RSVD(RSVD)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .func    (func),
    .vaddr   (vaddr),
    .paddr   (paddr),
    .miss_k  (miss_k),
    .miss_u  (miss_u),
    .invalid (invalid),
    .wprot   (wprot),
    .idx_we  (idx_we),
    .ehi_we  (ehi_we),
    .elo_we  (elo_we),
    .rnd     (rnd_idx)
);

// File: tb/xlate_unit_bench.sv
// Self-checking bench for xlate_unit: a vector table, then directed sequences.
module xlate_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  func = 3'd0;
    logic [31:0] vaddr = '0, idx_reg = '0, ehi_reg = '0, elo_reg = '0;
    logic [31:0] paddr, idx_new, ehi_new, elo_new;
    logic        miss_k, miss_u, invalid, wprot, idx_we, ehi_we, elo_we;
    int          n_chk = 0;
    int          n_bad = 0;

    always #2 clk = ~clk;

    xlate_unit u_xlate_unit (
        .clk(clk), .rst_n(rst_n), .func(func), .vaddr(vaddr),
        .idx_reg(idx_reg), .ehi_reg(ehi_reg), .elo_reg(elo_reg),
        .paddr(paddr), .miss_k(miss_k), .miss_u(miss_u),
        .invalid(invalid), .wprot(wprot),
        .idx_we(idx_we), .idx_new(idx_new),
        .ehi_we(ehi_we), .ehi_new(ehi_new),
        .elo_we(elo_we), .elo_new(elo_new)
    );

    typedef struct packed {
        logic [2:0]  f;
        logic [31:0] va;
        logic [31:0] ix;
        logic [31:0] hi;
        logic [31:0] lo;
        logic        chk;
        logic [31:0] pa;
        logic [3:0]  fl;   // {miss_k, miss_u, invalid, wprot}
    } row_t;

    localparam int NROWS = 18;
    localparam row_t TBL [NROWS] = '{
        // R9: indexed writes fill slots
        '{3'd5, 32'h0, 32'd5,  32'h00010000, 32'h00ABC003, 1'b0, 32'h0, 4'h0},
        '{3'd5, 32'h0, 32'd7,  32'h00020000, 32'h00123001, 1'b0, 32'h0, 4'h0},
        '{3'd5, 32'h0, 32'd9,  32'h00030000, 32'h00456002, 1'b0, 32'h0, 4'h0},
        '{3'd5, 32'h0, 32'd2,  32'h80040000, 32'h00789003, 1'b0, 32'h0, 4'h0},
        '{3'd5, 32'h0, 32'd12, 32'h00050000, 32'h00111003, 1'b0, 32'h0, 4'h0},
        '{3'd5, 32'h0, 32'd20, 32'h00050000, 32'h00222003, 1'b0, 32'h0, 4'h0},
        // R2: plain hit
        '{3'd1, 32'h00010345, 32'h0, 32'h0, 32'h0, 1'b1, 32'h00ABC345, 4'b0000},
        // R6: hold
        '{3'd0, 32'h0, 32'h0, 32'h0, 32'h0, 1'b1, 32'h00ABC345, 4'b0000},
        // R3: write bit clear
        '{3'd1, 32'h00020FFF, 32'h0, 32'h0, 32'h0, 1'b1, 32'h00123FFF, 4'b0001},
        // R3: valid bit clear
        '{3'd1, 32'h00030001, 32'h0, 32'h0, 32'h0, 1'b1, 32'h00456001, 4'b0010},
        // R2: kernel-half hit
        '{3'd1, 32'h80040010, 32'h0, 32'h0, 32'h0, 1'b1, 32'h00789010, 4'b0000},
        // R4: user miss
        '{3'd1, 32'h00060000, 32'h0, 32'h0, 32'h0, 1'b1, 32'h00000000, 4'b0100},
        // R4: kernel miss
        '{3'd1, 32'h80060000, 32'h0, 32'h0, 32'h0, 1'b1, 32'h00000000, 4'b1000},
        // R6: hold keeps a miss
        '{3'd0, 32'h0, 32'h0, 32'h0, 32'h0, 1'b1, 32'h00000000, 4'b1000},
        // R5: bypass
        '{3'd1, 32'hC1234567, 32'h0, 32'h0, 32'h0, 1'b1, 32'h01234567, 4'b0000},
        '{3'd1, 32'hFFFFFFFF, 32'h0, 32'h0, 32'h0, 1'b1, 32'h3FFFFFFF, 4'b0000},
        // R11: lowest slot wins
        '{3'd1, 32'h000500AB, 32'h0, 32'h0, 32'h0, 1'b1, 32'h001110AB, 4'b0000},
        // R4: only bit 30 set is not bypass
        '{3'd1, 32'h40001222, 32'h0, 32'h0, 32'h0, 1'b1, 32'h00000000, 4'b0100}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_op(input logic [2:0] f, input logic [31:0] va,
                         input logic [31:0] ix, input logic [31:0] hi, input logic [31:0] lo);
        @(negedge clk);
        func = f; vaddr = va; idx_reg = ix; ehi_reg = hi; elo_reg = lo;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1 paddr", paddr, 32'h0);
        check("R1 flags", {28'h0, miss_k, miss_u, invalid, wprot}, 32'h0);
        check("R1 we", {29'h0, idx_we, ehi_we, elo_we}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NROWS; i++) begin
            do_op(TBL[i].f, TBL[i].va, TBL[i].ix, TBL[i].hi, TBL[i].lo);
            if (TBL[i].chk) begin
                check($sformatf("R2 row %0d paddr", i), paddr, TBL[i].pa);
                check($sformatf("R3 row %0d flags", i),
                      {28'h0, miss_k, miss_u, invalid, wprot}, {28'h0, TBL[i].fl});
            end
        end

        // R7 and R11: search finds the lower of two matching slots
        do_op(3'd2, 32'h0, 32'h0, 32'h00050000, 32'h0);
        check("R7 idx_we", {31'h0, idx_we}, 32'd1);
        check("R11 idx_new", idx_new, 32'd12);
        do_op(3'd0, 32'h0, 32'h0, 32'h0, 32'h0);
        check("R12 idx_we drops", {31'h0, idx_we}, 32'd0);
        // R7: no match marker
        do_op(3'd2, 32'h0, 32'h0, 32'h00777000, 32'h0);
        check("R7 idx_new miss", idx_new, 32'h80000000);

        // R8: indexed read
        do_op(3'd4, 32'h0, 32'd7, 32'h0, 32'h0);
        check("R8 we", {30'h0, ehi_we, elo_we}, 32'd3);
        check("R8 ehi_new", ehi_new, 32'h00020000);
        check("R8 elo_new", elo_new, 32'h00123001);
        check("R12 idx_we on read", {31'h0, idx_we}, 32'd0);

        // R10: ten maps so far, slot is 21
        do_op(3'd3, 32'h0, 32'h0, 32'h00099000, 32'h00AAA003);
        check("R12 no we on write", {29'h0, idx_we, ehi_we, elo_we}, 32'h0);
        do_op(3'd2, 32'h0, 32'h0, 32'h00099000, 32'h0);
        check("R10 slot 21", idx_new, 32'd21);
        do_op(3'd1, 32'h00099010, 32'h0, 32'h0, 32'h0);
        check("R10 map new entry", paddr, 32'h00AAA010);
        check("R12 no we on map", {29'h0, idx_we, ehi_we, elo_we}, 32'h0);

        // R10: step down to the lowest usable slot
        for (int k = 0; k < 16; k++) do_op(3'd1, 32'hC0000000, 32'h0, 32'h0, 32'h0);
        do_op(3'd3, 32'h0, 32'h0, 32'h000BB000, 32'h00CCC003);
        do_op(3'd2, 32'h0, 32'h0, 32'h000BB000, 32'h0);
        check("R10 slot 4", idx_new, 32'd4);
        do_op(3'd1, 32'hC0000000, 32'h0, 32'h0, 32'h0);
        do_op(3'd3, 32'h0, 32'h0, 32'h000DD000, 32'h00EEE003);
        do_op(3'd2, 32'h0, 32'h0, 32'h000DD000, 32'h0);
        check("R10 wrap to 31", idx_new, 32'd31);

        // R1: reset again mid-run
        @(negedge clk);
        rst_n = 1'b0;
        func = 3'd0;
        @(posedge clk);
        #1;
        check("R1 paddr after reset", paddr, 32'h0);
        check("R1 we after reset", {29'h0, idx_we, ehi_we, elo_we}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: entries cleared and slot back at the top
        do_op(3'd4, 32'h0, 32'd5, 32'h0, 32'h0);
        check("R1 entry cleared", elo_new, 32'h0);
        do_op(3'd3, 32'h0, 32'h0, 32'h000EE000, 32'h00FFF003);
        do_op(3'd2, 32'h0, 32'h0, 32'h000EE000, 32'h0);
        check("R1 slot reset 31", idx_new, 32'd31);

        finish_run();
    end
endmodule